// File: doc/BRIEF.md
# Dual Timewheel Wakeup Unit

This unit keeps two coarse timers that run from low-speed oscillator ticks, for waking a system from low-power states and for rough interval timing. Both tick inputs arrive as single-cycle enables. Each one passes through a two-flop synchronizer and a rising-edge detector, so everything else runs on the one system clock.

The slow wheel is a 13-bit counter that advances on each 1 kHz tick and wraps freely. It stops while the hibernate or debug-halt flag is high. A selectable counter bit defines its wake period. The fast wheel is a 5-bit counter that advances on each 100 kHz tick. When it reaches a programmable terminal count it reloads to zero by itself. Each wheel drives a one-cycle wake pulse and a sticky interrupt status bit that can be masked. A divide-by-3 stage turns the 100 kHz tick into a roughly 33 kHz tick.

Software sees four word addresses: control, status, slow count and fast count.

Top module: `twheel_wake`

## Requirements
- R1: After reset, all four registers read 0, and slow_wake_o, fast_wake_o, slow_irq_o, fast_irq_o and tick_33k_o are low.
- R2: The slow count (address 2, bits 12:0) increases by one for each synchronized 1 kHz tick and wraps from 8191 to 0.
- R3: While hib_i or dbg_halt_i is high, 1 kHz ticks leave the slow count unchanged.
- R4: Any write to address 2 sets the slow count to 0. This clear takes priority over a tick in the same cycle.
- R5: The slow wake event occurs only when control bit 0 is set. It fires when the count step makes the selected bit go from 0 to 1. Control bits 7:4 select bit k (0..12), which gives a period of 2^(k+1) ticks. Select values 13..15 behave as 12. slow_wake_o pulses for one clock cycle.
- R6: Control bit 2 enables the fast wheel, and control bits 12:8 hold its terminal count T. While enabled, the fast count (address 3, bits 4:0) steps on each 100 kHz tick. At T it returns to 0 and fast_wake_o pulses for one cycle. T = 0 therefore gives an event on every tick. While disabled, the fast count is held at 0.
- R7: Status bits (address 1) are set by events: bit 0 by slow events, bit 1 by fast events. They stay set until software writes 1 to that bit, and a new event in the same cycle wins. slow_irq_o is status bit 0 AND control bit 1. fast_irq_o is status bit 1 AND control bit 3. The wake pulses do not depend on these mask bits.
- R8: tick_33k_o pulses for one cycle on every third synchronized 100 kHz tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1k_i | input | 1 | 1 kHz tick enable, asynchronous |
| tick_100k_i | input | 1 | 100 kHz tick enable, asynchronous |
| hib_i | input | 1 | Hibernate state flag |
| dbg_halt_i | input | 1 | Debug CPU-halted flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| slow_wake_o | output | 1 | Slow wheel wake pulse |
| fast_wake_o | output | 1 | Fast wheel wake pulse |
| slow_irq_o | output | 1 | Slow wheel masked interrupt |
| fast_irq_o | output | 1 | Fast wheel masked interrupt |
| tick_33k_o | output | 1 | Divided 33 kHz tick |

## Verification
A tick, clear or reload that goes wrong inside the unit shows up in the count read back on the very next access. The wake pulse appears in the same cycle as the faulty count step. A tick takes three clock edges to reach the counters. Because of that, every check waits several cycles after each tick before it reads anything. A bad tap selection or a wrong terminal-count compare does not show on the first tick. It shows as a wrong number of wake pulses over a complete period, so the tests count pulses over whole periods. They also cover the 13-bit wrap and the clamped select values.

// File: rtl/twheel_wake.sv
module twheel_wake #(
  parameter int SLOW_W = 13,
  parameter int FAST_W = 5,
  parameter int SEL_W  = 4,
  parameter int AW     = 2,
  parameter int DW     = 16,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1k_i,
  input  logic          tick_100k_i,
  input  logic          hib_i,
  input  logic          dbg_halt_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          slow_wake_o,
  output logic          fast_wake_o,
  output logic          slow_irq_o,
  output logic          fast_irq_o,
  output logic          tick_33k_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_SLOW = AW'(2);
  localparam logic [AW-1:0] A_FAST = AW'(3);
  localparam int SEL_LO = 4;
  localparam int TC_LO  = 8;
  localparam int CTRL_W = TC_LO + FAST_W;
  localparam logic [SEL_W-1:0] MAX_TAP = SEL_W'(SLOW_W - 1);

  logic [SYNC_N:0] s1k, s100k;
  logic r1k, r100k;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1k   <= '0;
      s100k <= '0;
    end else begin
      s1k   <= {s1k[SYNC_N-1:0], tick_1k_i};
      s100k <= {s100k[SYNC_N-1:0], tick_100k_i};
    end

  assign r1k   = s1k[SYNC_N-1]   & ~s1k[SYNC_N];
  assign r100k = s100k[SYNC_N-1] & ~s100k[SYNC_N];

  logic [CTRL_W-1:0] ctrl;
  logic sw_en, si_en, f_en, fi_en;
  logic [SEL_W-1:0]  sel, tap;
  logic [FAST_W-1:0] tc;

  assign sw_en = ctrl[0];
  assign si_en = ctrl[1];
  assign f_en  = ctrl[2];
  assign fi_en = ctrl[3];
  assign sel   = ctrl[SEL_LO +: SEL_W];
  assign tc    = ctrl[TC_LO +: FAST_W];
  assign tap   = (sel > MAX_TAP) ? MAX_TAP : sel;

  logic wr_ctrl, wr_stat, slow_clr;
  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_stat  = reg_we_i && (reg_addr_i == A_STAT);
  assign slow_clr = reg_we_i && (reg_addr_i == A_SLOW);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= reg_wdata_i[CTRL_W-1:0];

  logic [SLOW_W-1:0] slow_cnt, slow_nxt;
  logic slow_adv, slow_evt;

  assign slow_nxt = slow_cnt + SLOW_W'(1);
  assign slow_adv = r1k & ~hib_i & ~dbg_halt_i & ~slow_clr;
  assign slow_evt = slow_adv & sw_en & slow_nxt[tap] & ~slow_cnt[tap];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        slow_cnt <= '0;
    else if (slow_clr) slow_cnt <= '0;
    else if (slow_adv) slow_cnt <= slow_nxt;

  logic [FAST_W-1:0] fast_cnt;
  logic fast_hit, fast_evt;

  assign fast_hit = (fast_cnt == tc);
  assign fast_evt = f_en & r100k & fast_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     fast_cnt <= '0;
    else if (!f_en) fast_cnt <= '0;
    else if (r100k) fast_cnt <= fast_hit ? '0 : fast_cnt + FAST_W'(1);

  logic [1:0] div3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div3       <= '0;
      tick_33k_o <= 1'b0;
    end else begin
      tick_33k_o <= r100k && (div3 == 2'd2);
      if (r100k) div3 <= (div3 == 2'd2) ? 2'd0 : div3 + 2'd1;
    end

  logic sts_slow, sts_fast;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts_slow    <= 1'b0;
      sts_fast    <= 1'b0;
      slow_wake_o <= 1'b0;
      fast_wake_o <= 1'b0;
    end else begin
      slow_wake_o <= slow_evt;
      fast_wake_o <= fast_evt;
      sts_slow    <= slow_evt | (sts_slow & ~(wr_stat & reg_wdata_i[0]));
      sts_fast    <= fast_evt | (sts_fast & ~(wr_stat & reg_wdata_i[1]));
    end

  assign slow_irq_o = sts_slow & si_en;
  assign fast_irq_o = sts_fast & fi_en;

  always_comb
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = DW'(ctrl);
      A_STAT:  reg_rdata_o = DW'({sts_fast, sts_slow});
      A_SLOW:  reg_rdata_o = DW'(slow_cnt);
      default: reg_rdata_o = DW'(fast_cnt);
    endcase
endmodule

// File: rtl/twheel_wake_chk.sv
module twheel_wake_chk #(
  parameter int SLOW_W = 13,
  parameter int FAST_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hib_i,
  input logic              dbg_halt_i,
  input logic              slow_clr,
  input logic [SLOW_W-1:0] slow_cnt,
  input logic [FAST_W-1:0] fast_cnt,
  input logic              slow_wake_o,
  input logic              fast_wake_o,
  input logic              sts_fast,
  input logic              tick_33k_o
);
  AST_SLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_clr |=> (slow_cnt == $past(slow_cnt)) || (slow_cnt == $past(slow_cnt) + SLOW_W'(1))); // R2
  AST_SLOW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_i || dbg_halt_i) && !slow_clr |=> $stable(slow_cnt)); // R3
  AST_SLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    slow_clr |=> slow_cnt == '0); // R4
  AST_SLOW_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    slow_wake_o |=> !slow_wake_o); // R5
  AST_FAST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fast_wake_o |-> fast_cnt == '0); // R6
  AST_FAST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fast_wake_o |-> sts_fast); // R7
  AST_DIV3_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_33k_o |=> !tick_33k_o); // R8
endmodule

bind twheel_wake twheel_wake_chk #(.SLOW_W(SLOW_W), .FAST_W(FAST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hib_i(hib_i), .dbg_halt_i(dbg_halt_i),
  .slow_clr(slow_clr), .slow_cnt(slow_cnt), .fast_cnt(fast_cnt),
  .slow_wake_o(slow_wake_o), .fast_wake_o(fast_wake_o),
  .sts_fast(sts_fast), .tick_33k_o(tick_33k_o)
);

// File: tb/sim_twheel_wake.sv
`timescale 1ns/1ps
module sim_twheel_wake;
  logic clk = 0, rst_n = 0;
  logic t1k = 0, t100k = 0, hib = 0, halt = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic sw, fw, si, fi, t33;
  int total = 0, bad = 0, sw_n = 0, fw_n = 0, t33_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twheel_wake u0 (.clk(clk), .rst_n(rst_n), .tick_1k_i(t1k), .tick_100k_i(t100k),
    .hib_i(hib), .dbg_halt_i(halt), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .slow_wake_o(sw), .fast_wake_o(fw),
    .slow_irq_o(si), .fast_irq_o(fi), .tick_33k_o(t33));

  always @(negedge clk) if (rst_n) begin
    if (sw)  sw_n++;
    if (fw)  fw_n++;
    if (t33) t33_n++;
  end

  // {tc, ticks, expected wakes, expected final count}
  localparam logic [31:0] VEC [5] = '{
    {8'd0, 8'd5, 8'd5, 8'd0}, {8'd3, 8'd10, 8'd2, 8'd2}, {8'd7, 8'd8, 8'd1, 8'd0},
    {8'd31, 8'd40, 8'd1, 8'd8}, {8'd1, 8'd7, 8'd3, 8'd1}};

  function automatic logic [15:0] cw(bit swe, bit sie, bit fe, bit fie, int s, int t);
    return (16'(t) << 8) | (16'(s) << 4) | {12'd0, fie, fe, sie, swe};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk) #1; we = 1; addr = a; wdata = d;
    @(posedge clk) #1; we = 0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    @(negedge clk); addr = a; #1; d = int'(rdata);
  endtask

  task automatic tk1(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk) #1; t1k = 1;
      @(posedge clk) #1; t1k = 0;
      repeat (5) @(posedge clk);
    end
  endtask

  task automatic tk100(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk) #1; t100k = 1;
      @(posedge clk) #1; t100k = 0;
      repeat (5) @(posedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg", v, 0); end
    @(negedge clk);
    chk("R1 outs", int'({sw, fw, si, fi, t33}), 0);

    // fast wheel table
    foreach (VEC[k]) begin
      wr(0, 16'd0);
      wr(0, cw(0, 0, 1, 0, 0, int'(VEC[k][31:24])));
      fw_n = 0;
      tk100(int'(VEC[k][23:16]));
      chk("R6 wakes (R7 no mask)", fw_n, int'(VEC[k][15:8]));
      rd(3, v); chk("R6 count", v, int'(VEC[k][7:0]));
    end
    wr(1, 16'h3);

    // slow wheel basics
    sw_n = 0;
    wr(0, cw(1, 0, 0, 0, 0, 0));
    tk1(4);
    rd(2, v); chk("R2 count", v, 4);
    chk("R5 tap0 wakes", sw_n, 2);
    rd(1, v); chk("R7 sticky", v, 1);
    @(negedge clk); chk("R7 masked irq", int'(si), 0);
    wr(0, cw(1, 1, 0, 0, 0, 0));
    @(negedge clk); chk("R7 irq on", int'(si), 1);
    wr(1, 16'h1);
    rd(1, v); chk("R7 w1c", v, 0);
    @(negedge clk); chk("R7 irq off", int'(si), 0);

    // freeze
    hib = 1; tk1(3); rd(2, v); chk("R3 hib", v, 4); hib = 0;
    halt = 1; tk1(3); rd(2, v); chk("R3 halt", v, 4); halt = 0;
    tk1(1); rd(2, v); chk("R2 resume", v, 5);

    // clear
    wr(2, 16'hffff); rd(2, v); chk("R4 clear", v, 0);

    // tap select
    wr(0, cw(1, 0, 0, 0, 2, 0)); sw_n = 0;
    tk1(8); chk("R5 tap2", sw_n, 1);
    wr(0, cw(0, 0, 0, 0, 0, 0)); sw_n = 0;
    tk1(4); chk("R5 disabled", sw_n, 0);
    wr(0, cw(1, 0, 0, 0, 15, 0)); wr(2, 0); sw_n = 0;
    tk1(8192);
    rd(2, v); chk("R2 wrap", v, 0);
    chk("R5 clamp", sw_n, 1);

    // fast irq
    wr(1, 16'h3);
    wr(0, cw(0, 0, 1, 1, 0, 2));
    tk100(3);
    @(negedge clk); chk("R7 fast irq", int'(fi), 1);
    wr(1, 16'h2);
    @(negedge clk); chk("R7 fast clr", int'(fi), 0);

    // disabled fast wheel and divide by 3
    wr(0, 16'd0); fw_n = 0; t33_n = 0;
    tk100(9);
    rd(3, v); chk("R6 held", v, 0);
    chk("R6 no wake", fw_n, 0);
    chk("R8 div3", t33_n, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule